// File: doc/BRIEF.md
# Gyroscope SPI Register Model

This block is a synthesizable SPI target that answers like the register interface of a two-axis rate gyroscope. It is meant for emulation platforms and test benches that need something on the far side of an SPI host controller. The block decodes a command byte, serves single and burst reads from a byte-wide register map, and accepts writes to its three control registers: power, filter and data-ready routing.

A parallel stimulus port carries new roll-rate, pitch-rate and temperature samples into the map. A sample is taken only while measurement mode is on and a configurable settle time has passed since it was switched on. A sample that arrives in the middle of an SPI frame waits in a one-deep slot and is committed when chip select goes high. Each committed sample raises a data-ready flag. The flag drops once a read frame has clocked out the high byte of the pitch rate. The flag reaches the output pin only when measurement mode is on and the routing field selects it.

All SPI inputs are oversampled by the system clock. The bus uses mode 0: the clock idles low, MOSI is sampled on the rising edge, MISO changes after the falling edge, and bits go most significant first.

Top module: `gyro_spi_regmodel`

## Requirements
- R1: The first byte of a frame is a command. Bit 7 set means read and bit 7 clear means write; bits 6:0 give the start address. Read data starts with the byte that follows the command. MISO is low while chip select is high.
- R2: Address 0x00 reads 0xAD, 0x01 reads 0x1D and 0x02 reads 0x92. Writes to these addresses leave them unchanged.
- R3: Addresses 0x04 to 0x07 return the bytes of the SERIAL_NUM parameter, least significant byte at 0x04.
- R4: In a frame with more than one data byte, the address advances by one after each byte, for reads and for writes. It wraps from 0x7F to 0x00.
- R5: Addresses 0x03, 0x0E, 0x0F and 0x13 to 0x7F read 0x00, and writes to them are ignored.
- R6: Address 0x10 keeps written bits 1:0 (bit 1 measurement on, bit 0 temperature sensor on). Its other bits read 0 and it resets to 0x00.
- R7: Address 0x11 keeps written bits 2:0 and 7:4. Bit 3 reads 0 and the register resets to 0x00.
- R8: Address 0x12 keeps written bits 1:0. Its other bits read 0.
- R9: Sample bytes are laid out low byte first: X rate at 0x08/0x09, Y rate at 0x0A/0x0B, and temperature at 0x0C (bits 7:0) and 0x0D (bits 3:0 hold temperature bits 11:8, bits 7:4 read 0). All sample bytes reset to 0.
- R10: A sample strobe is ignored unless measurement is on and SETTLE_CYC clock cycles have passed since it was switched on. Temperature is updated only while the temperature sensor bit is set; the rates are updated either way.
- R11: A sample that arrives while chip select is low is committed only after the frame ends, so every byte of a burst comes from one sample set.
- R12: Committing a sample sets the data-ready flag. A read frame clears the flag when it finishes clocking out address 0x0B. Reading other addresses leaves the flag set.
- R13: drdy_o is high only when the flag is set, measurement is on and 0x12 bits 1:0 equal 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk_i | input | 1 | SPI serial clock, idles low |
| spi_cs_n_i | input | 1 | SPI chip select, active low |
| spi_mosi_i | input | 1 | Serial data from the host |
| spi_miso_o | output | 1 | Serial data to the host |
| smp_stb_i | input | 1 | One-cycle strobe that offers a new sample |
| smp_xrate_i | input | 16 | X (roll) rate sample |
| smp_yrate_i | input | 16 | Y (pitch) rate sample |
| smp_temp_i | input | 12 | Temperature sample, two's complement |
| drdy_o | output | 1 | Data-ready output pin |

## Verification
The bench sweeps every unmapped address and reads bursts that cross the 0x7F wrap and the identity bytes. A design with a broken read mux or a missing wrap would return stale or nonzero bytes there. It strobes samples with measurement off and again inside the settle window, where a design that ignores the gate would change the rate bytes or raise data-ready. It reads only part of the rate block to show that the flag survives until 0x0B has been sent; a design that clears the flag on any data read would fail this. It also fires a sample in the middle of a burst; a design without the pending slot would return a torn mix of old and new bytes.

// File: rtl/gyro_pkg.sv
package gyro_pkg;
   localparam int BYTE_W = 8;
   localparam int ADDR_W = 7;
   localparam int RATE_W = 16;
   localparam int TEMP_W = 12;

   typedef logic [BYTE_W-1:0] byte_t;
   typedef logic [ADDR_W-1:0] addr_t;

   localparam addr_t A_VENDOR = 7'h00;
   localparam addr_t A_SENSOR = 7'h01;
   localparam addr_t A_PART   = 7'h02;
   localparam addr_t A_SER0   = 7'h04;
   localparam addr_t A_SER1   = 7'h05;
   localparam addr_t A_SER2   = 7'h06;
   localparam addr_t A_SER3   = 7'h07;
   localparam addr_t A_XLO    = 7'h08;
   localparam addr_t A_XHI    = 7'h09;
   localparam addr_t A_YLO    = 7'h0A;
   localparam addr_t A_YHI    = 7'h0B;
   localparam addr_t A_TLO    = 7'h0C;
   localparam addr_t A_THI    = 7'h0D;
   localparam addr_t A_PWR    = 7'h10;
   localparam addr_t A_FILT   = 7'h11;
   localparam addr_t A_ROUTE  = 7'h12;

   localparam byte_t VENDOR_CODE = 8'hAD;
   localparam byte_t SENSOR_CODE = 8'h1D;
   localparam byte_t PART_CODE   = 8'h92;
   localparam byte_t FILT_MASK   = 8'hF7;

   localparam logic [1:0] ROUTE_DRDY = 2'b01;

   typedef enum logic [1:0] {
      XS_CMD,
      XS_RD,
      XS_WR
   } xact_st_e;
endpackage

// File: rtl/gyro_spi_phy.sv
module gyro_spi_phy import gyro_pkg::*; #(
   parameter int SYNC_STAGES = 2
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  sclk_i,
   input  logic  cs_n_i,
   input  logic  mosi_i,
   output logic  miso_o,
   output logic  frame_active_o,
   output logic  byte_stb_o,
   output byte_t rx_byte_o,
   input  logic  tx_load_i,
   input  byte_t tx_byte_i
);
   localparam int CNT_W = $clog2(BYTE_W);

   logic [SYNC_STAGES-1:0] sclk_pipe, cs_pipe, mosi_pipe;
   logic                   sclk_s, mosi_s, sclk_prev_q;
   logic                   rise, fall;
   logic [CNT_W-1:0]       bit_cnt_q;
   logic [BYTE_W-2:0]      rx_q;
   byte_t                  tx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_pipe <= '0;
         cs_pipe   <= '1;
         mosi_pipe <= '0;
      end else begin
         sclk_pipe <= {sclk_pipe[SYNC_STAGES-2:0], sclk_i};
         cs_pipe   <= {cs_pipe[SYNC_STAGES-2:0], cs_n_i};
         mosi_pipe <= {mosi_pipe[SYNC_STAGES-2:0], mosi_i};
      end
   end

   assign sclk_s         = sclk_pipe[SYNC_STAGES-1];
   assign mosi_s         = mosi_pipe[SYNC_STAGES-1];
   assign frame_active_o = !cs_pipe[SYNC_STAGES-1];
   assign rise           = frame_active_o && sclk_s && !sclk_prev_q;
   assign fall           = frame_active_o && !sclk_s && sclk_prev_q;
   assign byte_stb_o     = rise && (bit_cnt_q == CNT_W'(BYTE_W-1));
   assign rx_byte_o      = {rx_q, mosi_s};
   assign miso_o         = tx_q[BYTE_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_prev_q <= 1'b0;
         bit_cnt_q   <= '0;
         rx_q        <= '0;
         tx_q        <= '0;
      end else begin
         sclk_prev_q <= sclk_s;
         if (!frame_active_o) begin
            bit_cnt_q <= '0;
            tx_q      <= '0;
         end else begin
            if (rise) begin
               bit_cnt_q <= bit_cnt_q + 1'b1;
               rx_q      <= rx_byte_o[BYTE_W-2:0];
            end
            if (tx_load_i)
               tx_q <= tx_byte_i;
            else if (fall && bit_cnt_q != '0)
               tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
         end
      end
   end

   // R1
   tx_load_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_load_i |-> byte_stb_o)
      else $error("tx load outside a byte boundary");

   // R1
   miso_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_active_o |=> !miso_o)
      else $error("miso driven while deselected");
endmodule

// File: rtl/gyro_xact.sv
module gyro_xact import gyro_pkg::*; (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  frame_active_i,
   input  logic  byte_stb_i,
   input  byte_t rx_byte_i,
   output addr_t rd_addr_o,
   output logic  tx_load_o,
   output logic  wr_en_o,
   output addr_t wr_addr_o,
   output byte_t wr_data_o,
   output logic  drdy_clr_o
);
   xact_st_e state_q;
   addr_t    cur_q;
   logic     is_read_cmd;

   assign is_read_cmd = rx_byte_i[BYTE_W-1];

   always_comb begin
      rd_addr_o  = (state_q == XS_CMD) ? rx_byte_i[ADDR_W-1:0] : cur_q + 1'b1;
      tx_load_o  = byte_stb_i && ((state_q == XS_CMD && is_read_cmd) || state_q == XS_RD);
      wr_en_o    = byte_stb_i && (state_q == XS_WR);
      wr_addr_o  = cur_q;
      wr_data_o  = rx_byte_i;
      drdy_clr_o = byte_stb_i && (state_q == XS_RD) && (cur_q == A_YHI);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= XS_CMD;
         cur_q   <= '0;
      end else if (!frame_active_i) begin
         state_q <= XS_CMD;
         cur_q   <= '0;
      end else if (byte_stb_i) begin
         if (state_q == XS_CMD) begin
            cur_q   <= rx_byte_i[ADDR_W-1:0];
            state_q <= is_read_cmd ? XS_RD : XS_WR;
         end else begin
            cur_q <= cur_q + 1'b1;
         end
      end
   end

   // R1
   cmd_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_active_i) |-> state_q == XS_CMD)
      else $error("frame did not start in command phase");
endmodule

// File: rtl/gyro_regmap.sv
module gyro_regmap import gyro_pkg::*; #(
   parameter int          SETTLE_CYC = 64,
   parameter logic [31:0] SERIAL_NUM = 32'h0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_active_i,
   input  addr_t             rd_addr_i,
   output byte_t             rd_data_o,
   input  logic              wr_en_i,
   input  addr_t             wr_addr_i,
   input  byte_t             wr_data_i,
   input  logic              drdy_clr_i,
   input  logic              smp_stb_i,
   input  logic [RATE_W-1:0] smp_x_i,
   input  logic [RATE_W-1:0] smp_y_i,
   input  logic [TEMP_W-1:0] smp_t_i,
   output logic              drdy_o
);
   logic [1:0]        pwr_q, route_q;
   byte_t             filt_q;
   logic [RATE_W-1:0] x_q, y_q, px_q, py_q;
   logic [TEMP_W-1:0] t_q, pt_q;
   logic              pend_q, drdy_q, meas, acc_rdy, commit;

   assign meas = pwr_q[1];

   if (SETTLE_CYC == 0) begin : g_no_settle
      assign acc_rdy = meas;
   end else begin : g_settle
      localparam int SW = $clog2(SETTLE_CYC + 1);
      logic [SW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cnt_q <= '0;
         else if (!meas)
            cnt_q <= '0;
         else if (cnt_q != SW'(SETTLE_CYC))
            cnt_q <= cnt_q + 1'b1;
      end
      assign acc_rdy = meas && (cnt_q == SW'(SETTLE_CYC));
   end

   always_comb begin
      case (rd_addr_i)
         A_VENDOR: rd_data_o = VENDOR_CODE;
         A_SENSOR: rd_data_o = SENSOR_CODE;
         A_PART:   rd_data_o = PART_CODE;
         A_SER0:   rd_data_o = SERIAL_NUM[7:0];
         A_SER1:   rd_data_o = SERIAL_NUM[15:8];
         A_SER2:   rd_data_o = SERIAL_NUM[23:16];
         A_SER3:   rd_data_o = SERIAL_NUM[31:24];
         A_XLO:    rd_data_o = x_q[7:0];
         A_XHI:    rd_data_o = x_q[15:8];
         A_YLO:    rd_data_o = y_q[7:0];
         A_YHI:    rd_data_o = y_q[15:8];
         A_TLO:    rd_data_o = t_q[7:0];
         A_THI:    rd_data_o = {4'b0, t_q[TEMP_W-1:8]};
         A_PWR:    rd_data_o = {6'b0, pwr_q};
         A_FILT:   rd_data_o = filt_q;
         A_ROUTE:  rd_data_o = {6'b0, route_q};
         default:  rd_data_o = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwr_q   <= '0;
         filt_q  <= '0;
         route_q <= '0;
      end else if (wr_en_i) begin
         case (wr_addr_i)
            A_PWR:   pwr_q   <= wr_data_i[1:0];
            A_FILT:  filt_q  <= wr_data_i & FILT_MASK;
            A_ROUTE: route_q <= wr_data_i[1:0];
            default: ;
         endcase
      end
   end

   assign commit = pend_q && !frame_active_i && acc_rdy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         px_q   <= '0;
         py_q   <= '0;
         pt_q   <= '0;
      end else if (!acc_rdy) begin
         pend_q <= 1'b0;
      end else if (smp_stb_i) begin
         pend_q <= 1'b1;
         px_q   <= smp_x_i;
         py_q   <= smp_y_i;
         pt_q   <= smp_t_i;
      end else if (commit) begin
         pend_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_q    <= '0;
         y_q    <= '0;
         t_q    <= '0;
         drdy_q <= 1'b0;
      end else begin
         if (commit) begin
            x_q <= px_q;
            y_q <= py_q;
            if (pwr_q[0])
               t_q <= pt_q;
         end
         if (commit)
            drdy_q <= 1'b1;
         else if (drdy_clr_i)
            drdy_q <= 1'b0;
      end
   end

   assign drdy_o = drdy_q && meas && (route_q == ROUTE_DRDY);

   // R11
   sample_hold_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_active_i && $past(frame_active_i) |-> $stable(x_q) && $stable(y_q) && $stable(t_q))
      else $error("sample registers changed inside a frame");

   // R10
   sample_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(x_q) || !$stable(y_q) |-> $past(acc_rdy))
      else $error("sample taken while not accepting");

   // R12
   drdy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drdy_clr_i |=> !drdy_q)
      else $error("data-ready not cleared");

   // R12
   drdy_set_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drdy_q) |-> !$past(frame_active_i))
      else $error("data-ready set inside a frame");
endmodule

// File: rtl/gyro_spi_regmodel.sv
module gyro_spi_regmodel import gyro_pkg::*; #(
   parameter int          SYNC_STAGES = 2,
   parameter int          SETTLE_CYC  = 64,
   parameter logic [31:0] SERIAL_NUM  = 32'h6B2C_0417
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sclk_i,
   input  logic              spi_cs_n_i,
   input  logic              spi_mosi_i,
   output logic              spi_miso_o,
   input  logic              smp_stb_i,
   input  logic [RATE_W-1:0] smp_xrate_i,
   input  logic [RATE_W-1:0] smp_yrate_i,
   input  logic [TEMP_W-1:0] smp_temp_i,
   output logic              drdy_o
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (SETTLE_CYC < 0) begin : g_bad_settle
      $error("SETTLE_CYC must not be negative");
   end

   logic  frame_active, byte_stb, tx_load, wr_en, drdy_clr;
   byte_t rx_byte, rd_data, wr_data;
   addr_t rd_addr, wr_addr;

   gyro_spi_phy #(.SYNC_STAGES(SYNC_STAGES)) u_phy (
      .clk            (clk),
      .rst_n          (rst_n),
      .sclk_i         (spi_sclk_i),
      .cs_n_i         (spi_cs_n_i),
      .mosi_i         (spi_mosi_i),
      .miso_o         (spi_miso_o),
      .frame_active_o (frame_active),
      .byte_stb_o     (byte_stb),
      .rx_byte_o      (rx_byte),
      .tx_load_i      (tx_load),
      .tx_byte_i      (rd_data)
   );

   gyro_xact u_xact (
      .clk            (clk),
      .rst_n          (rst_n),
      .frame_active_i (frame_active),
      .byte_stb_i     (byte_stb),
      .rx_byte_i      (rx_byte),
      .rd_addr_o      (rd_addr),
      .tx_load_o      (tx_load),
      .wr_en_o        (wr_en),
      .wr_addr_o      (wr_addr),
      .wr_data_o      (wr_data),
      .drdy_clr_o     (drdy_clr)
   );

   gyro_regmap #(.SETTLE_CYC(SETTLE_CYC), .SERIAL_NUM(SERIAL_NUM)) u_regmap (
      .clk            (clk),
      .rst_n          (rst_n),
      .frame_active_i (frame_active),
      .rd_addr_i      (rd_addr),
      .rd_data_o      (rd_data),
      .wr_en_i        (wr_en),
      .wr_addr_i      (wr_addr),
      .wr_data_i      (wr_data),
      .drdy_clr_i     (drdy_clr),
      .smp_stb_i      (smp_stb_i),
      .smp_x_i        (smp_xrate_i),
      .smp_y_i        (smp_yrate_i),
      .smp_t_i        (smp_temp_i),
      .drdy_o         (drdy_o)
   );
endmodule

// File: tb/gyro_spi_regmodel_bench.sv
module gyro_spi_regmodel_bench;
   localparam int          HALF   = 8;
   localparam int          SETTLE = 64;
   localparam logic [31:0] SER    = 32'hC3A5_0F96;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, stb = 1'b0;
   logic [15:0] xin = '0, yin = '0;
   logic [11:0] tin = '0;
   logic        miso, drdy;
   logic [7:0]  rbuf [0:15];
   int          n_chk = 0, n_fail = 0;

   always #10 clk = ~clk;

   gyro_spi_regmodel #(.SYNC_STAGES(2), .SETTLE_CYC(SETTLE), .SERIAL_NUM(SER)) u_gyro_spi_regmodel (
      .clk(clk), .rst_n(rst_n), .spi_sclk_i(sclk), .spi_cs_n_i(cs_n), .spi_mosi_i(mosi),
      .spi_miso_o(miso), .smp_stb_i(stb), .smp_xrate_i(xin), .smp_yrate_i(yin),
      .smp_temp_i(tin), .drdy_o(drdy));

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
      for (int i = 7; i >= 0; i--) begin
         mosi = tx[i];
         repeat (HALF) @(negedge clk);
         rx[i] = miso;
         sclk = 1'b1;
         repeat (HALF) @(negedge clk);
         sclk = 1'b0;
      end
   endtask

   task automatic frame_begin();
      cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic frame_end();
      repeat (HALF) @(negedge clk);
      cs_n = 1'b1;
      repeat (2*HALF) @(negedge clk);
   endtask

   task automatic rd_burst(input logic [6:0] addr, input int n);
      logic [7:0] d;
      frame_begin();
      xfer({1'b1, addr}, d);
      for (int i = 0; i < n; i++) xfer(8'h00, rbuf[i]);
      frame_end();
   endtask

   task automatic wr_reg(input logic [6:0] addr, input logic [7:0] v);
      logic [7:0] d;
      frame_begin();
      xfer({1'b0, addr}, d);
      xfer(v, d);
      frame_end();
   endtask

   task automatic load(input logic [15:0] x, input logic [15:0] y, input logic [11:0] t);
      @(negedge clk);
      xin = x; yin = y; tin = t; stb = 1'b1;
      @(negedge clk);
      stb = 1'b0;
      repeat (5) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog: got 0x0 expected 0x1");
      finish_run();
   end

   initial begin
      logic [15:0] ex, ey, ex_old, ey_old;
      logic [11:0] et, et_old;
      logic [7:0]  d;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // reset state
      chk("R13 reset drdy", drdy, 0);
      chk("R1 idle miso", miso, 0);
      rd_burst(7'h10, 3);
      chk("R6 reset power", rbuf[0], 0);
      chk("R7 reset filter", rbuf[1], 0);
      chk("R8 reset route", rbuf[2], 0);
      rd_burst(7'h08, 6);
      for (int i = 0; i < 6; i++) chk("R9 reset sample byte", rbuf[i], 0);

      // identity and serial
      rd_burst(7'h00, 1); chk("R1 single read 0x00", rbuf[0], 8'hAD);
      rd_burst(7'h01, 1); chk("R2 read 0x01", rbuf[0], 8'h1D);
      rd_burst(7'h02, 1); chk("R2 read 0x02", rbuf[0], 8'h92);
      rd_burst(7'h00, 3);
      chk("R4 burst 0x00", rbuf[0], 8'hAD);
      chk("R4 burst 0x01", rbuf[1], 8'h1D);
      chk("R4 burst 0x02", rbuf[2], 8'h92);
      rd_burst(7'h04, 4);
      for (int i = 0; i < 4; i++) chk("R3 serial byte", rbuf[i], 16'(SER[8*i +: 8]));

      // unmapped sweep
      for (int a = 3; a < 128; a++) begin
         if (a == 3 || a == 8'h0E || a == 8'h0F || a >= 8'h13) begin
            rd_burst(7'(a), 1);
            chk("R5 unmapped read", rbuf[0], 0);
         end
      end
      rd_burst(7'h7E, 4);
      chk("R4 wrap 0x7E", rbuf[0], 0);
      chk("R4 wrap 0x7F", rbuf[1], 0);
      chk("R4 wrap 0x00", rbuf[2], 8'hAD);
      chk("R4 wrap 0x01", rbuf[3], 8'h1D);

      // writes
      wr_reg(7'h00, 8'h55);
      rd_burst(7'h00, 1); chk("R2 write to identity ignored", rbuf[0], 8'hAD);
      wr_reg(7'h20, 8'hFF);
      rd_burst(7'h20, 1); chk("R5 write to unmapped ignored", rbuf[0], 0);
      for (int v = 0; v < 256; v += 17) begin
         wr_reg(7'h11, 8'(v));
         rd_burst(7'h11, 1);
         chk("R7 filter field mask", rbuf[0], 16'(v & 8'hF7));
      end
      wr_reg(7'h10, 8'hFC);
      rd_burst(7'h10, 1); chk("R6 power upper bits dropped", rbuf[0], 0);
      wr_reg(7'h12, 8'hFE);
      rd_burst(7'h12, 1); chk("R8 route mask", rbuf[0], 8'h02);
      // burst write: 0x11 then 0x12
      frame_begin(); xfer(8'h11, d); xfer(8'h35, d); xfer(8'h01, d); frame_end();
      rd_burst(7'h11, 2);
      chk("R4 burst write 0x11", rbuf[0], 8'h35);
      chk("R4 burst write 0x12", rbuf[1], 8'h01);

      // measurement off: ignored
      load(16'h1111, 16'h2222, 12'h333);
      chk("R13 drdy with measurement off", drdy, 0);
      rd_burst(7'h08, 2);
      chk("R10 sample ignored in standby", {rbuf[1], rbuf[0]}, 0);

      // inside settle window: ignored
      wr_reg(7'h10, 8'h03);
      load(16'h4444, 16'h5555, 12'h666);
      chk("R10 drdy inside settle window", drdy, 0);
      rd_burst(7'h08, 2);
      chk("R10 sample ignored while settling", {rbuf[1], rbuf[0]}, 0);
      repeat (SETTLE + 40) @(negedge clk);

      // sample patterns
      ex = '0; ey = '0; et = '0;
      for (int k = 1; k <= 6; k++) begin
         ex = 16'(k * 16'h2B3D) ^ 16'h8001;
         ey = 16'hFFFF - 16'(k * 16'h1357);
         et = (k == 6) ? 12'hFFF : 12'(k * 12'h2A7);
         load(ex, ey, et);
         chk("R12 drdy after sample", drdy, 1);
         if (k % 2 == 1) begin
            rd_burst(7'h08, 3);
            chk("R9 x low", rbuf[0], 16'(ex[7:0]));
            chk("R9 x high", rbuf[1], 16'(ex[15:8]));
            chk("R9 y low", rbuf[2], 16'(ey[7:0]));
            chk("R12 drdy kept before 0x0B", drdy, 1);
            rd_burst(7'h0B, 1);
            chk("R9 y high", rbuf[0], 16'(ey[15:8]));
            chk("R12 drdy cleared by 0x0B", drdy, 0);
            rd_burst(7'h0C, 2);
            chk("R9 temp", {rbuf[1], rbuf[0]}, {4'h0, et});
         end else begin
            rd_burst(7'h08, 6);
            chk("R9 x", {rbuf[1], rbuf[0]}, ex);
            chk("R9 y", {rbuf[3], rbuf[2]}, ey);
            chk("R9 temp upper nibble zero", {rbuf[5], rbuf[4]}, {4'h0, et});
            chk("R12 drdy cleared by burst", drdy, 0);
         end
      end

      // temperature sensor off
      ex_old = ex; ey_old = ey; et_old = et;
      wr_reg(7'h10, 8'h02);
      load(16'hA5A5, 16'h5A5A, 12'h123);
      rd_burst(7'h08, 6);
      chk("R10 x with temp off", {rbuf[1], rbuf[0]}, 16'hA5A5);
      chk("R10 temp held with sensor off", {rbuf[5], rbuf[4]}, {4'h0, et_old});
      wr_reg(7'h10, 8'h03);

      // routing field
      wr_reg(7'h12, 8'h00);
      load(16'h0F0F, 16'hF0F0, 12'h800);
      chk("R13 drdy gated by route", drdy, 0);
      wr_reg(7'h12, 8'h01);
      chk("R13 drdy routed", drdy, 1);
      wr_reg(7'h10, 8'h01);
      chk("R13 drdy gated by measurement", drdy, 0);
      wr_reg(7'h10, 8'h03);
      repeat (SETTLE + 10) @(negedge clk);
      chk("R13 flag kept through standby", drdy, 1);
      rd_burst(7'h0B, 1);
      chk("R12 drdy cleared", drdy, 0);

      // sample inside a frame
      ex_old = 16'h0F0F; ey_old = 16'hF0F0; et_old = 12'h800;
      frame_begin();
      xfer(8'h88, d);
      xfer(8'h00, rbuf[0]);
      load(16'hBEEF, 16'hCAFE, 12'h7AB);
      for (int i = 1; i < 6; i++) xfer(8'h00, rbuf[i]);
      frame_end();
      chk("R11 x consistent", {rbuf[1], rbuf[0]}, ex_old);
      chk("R11 y consistent", {rbuf[3], rbuf[2]}, ey_old);
      chk("R11 temp consistent", {rbuf[5], rbuf[4]}, {4'h0, et_old});
      chk("R11 drdy after deferred commit", drdy, 1);
      rd_burst(7'h08, 6);
      chk("R11 x after frame", {rbuf[1], rbuf[0]}, 16'hBEEF);
      chk("R11 y after frame", {rbuf[3], rbuf[2]}, 16'hCAFE);
      chk("R11 temp after frame", {rbuf[5], rbuf[4]}, 16'h07AB);
      chk("R1 idle miso at end", miso, 0);

      finish_run();
   end
endmodule